// File: doc/BRIEF.md
# Debounced Pushbutton Up/Down Counter

This block turns a raw, bouncing mechanical pushbutton into clean single steps of a small counter. The button level is brought into the clock domain by a two-stage synchroniser. A slow sampling tick then shifts it into a short history register. A step is taken only when that history shows exactly one low sample followed by an unbroken run of high samples. Debounce and rising-edge detection therefore come from one comparison, and the button never clocks anything.

A level input picks the step direction: high counts up, low counts down. The count wraps at both ends, and the output can drive LEDs directly. The history length and the tick period are parameters. A longer history or a slower tick tolerates longer bounce or a faster system clock.

Top module: `btn_step_counter`

## Requirements
- R1: While reset is asserted (rst_n low) and on the first clock after it is released, count reads 0.
- R2: With dir_up = 1 at the moment a press is recognised, count increases by exactly one.
- R3: With dir_up = 0 at the moment a press is recognised, count decreases by exactly one.
- R4: Counting up from the maximum value (15 for a 4-bit count) gives 0, and counting down from 0 gives the maximum value.
- R5: A press is recognised when the history, newest sample in bit 0, equals one 0 in its oldest bit followed by all 1s (0b01111 for a 5-sample history). Holding the button keeps the history at all 1s, so a held button yields exactly one step.
- R6: A high pulse on btn_raw that lasts fewer than HIST_LEN-1 sampling ticks produces no step, and count is unchanged afterwards.
- R7: Bounce made of toggles shorter than HIST_LEN-1 sampling ticks, on press or on release, produces exactly one step per press.
- R8: count changes only on a recognised press. Toggling dir_up while the button is idle leaves count unchanged.
- R9: The history register samples the synchronised button once every TICK_DIV clock cycles, and a press is recognised in at most one clock cycle per sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_raw | input | 1 | Raw, unsynchronised pushbutton level, high when pressed |
| dir_up | input | 1 | Step direction: 1 counts up, 0 counts down |
| count | output | CNT_W | Current counter value |

## Verification
The bench builds the block with TICK_DIV = 4 and HIST_LEN = 5, keeping CNT_W = 4. With these values one sample lasts four clocks and a full debounce window about twenty. Dozens of presses, bounce bursts and sub-threshold glitches then fit in a short run, and the 4-bit count passes through both wrap points many times. Random press lengths, bounce counts and directions are mixed with directed presses at 15 and at 0 and with direction toggles while the button is idle.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/bsc_sync.sv
module bsc_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic meta_q, stable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= 1'b0;
      stable_q <= 1'b0;
    end else begin
      meta_q   <= async_in;
      stable_q <= meta_q;
    end
  end

  assign sync_out = stable_q;
endmodule

// File: rtl/bsc_tick.sv
module bsc_tick #(
  parameter int TICK_DIV = 250000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(TICK_DIV);
      localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);
      logic [DW-1:0] div_q;
      logic [DW-1:0] gap_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                   div_q <= div_q + 1'b1;
      end

      assign tick = (div_q == LAST);

      // independent spacing monitor: cycles since the previous tick
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    gap_q <= '0;
        else if (tick) gap_q <= '0;
        else if (gap_q != LAST) gap_q <= gap_q + 1'b1;
      end

      AST_TICK_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R9
      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && $past(tick == 1'b0) && $past(gap_q) != '0) |-> ($past(gap_q) == LAST - 1'b1)); // R9
    end
  endgenerate
endmodule

// File: rtl/bsc_hist.sv
module bsc_hist #(
  parameter int HIST_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic btn_s,
  output logic press
);
  localparam logic [HIST_LEN-1:0] ARM_PAT = {1'b0, {(HIST_LEN-1){1'b1}}};

  logic [HIST_LEN-1:0] hist_q;
  logic                fresh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      fresh_q <= 1'b0;
    end else begin
      fresh_q <= tick;
      if (tick) hist_q <= {hist_q[HIST_LEN-2:0], btn_s};
    end
  end

  // one qualifying look per sample, right after the shift
  assign press = fresh_q && (hist_q == ARM_PAT);

  AST_PRESS_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    press |=> !press); // R9
  AST_PRESS_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    press |-> $past(tick)); // R9
  AST_HOLD_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (fresh_q && hist_q == '1) |-> !press); // R5
endmodule

// File: rtl/bsc_counter.sv
module bsc_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             press,
  input  logic             dir_up,
  output logic [CNT_W-1:0] count
);
  import bsc_pkg::*;

  localparam logic [CNT_W-1:0] TOP = '1;

  function automatic logic [CNT_W-1:0] step_of(input logic [CNT_W-1:0] c, input dir_e d);
    if (d == DIR_UP) return (c == TOP) ? '0 : c + 1'b1;
    else             return (c == '0) ? TOP : c - 1'b1;
  endfunction

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (press) cnt_q <= step_of(cnt_q, dir_e'(dir_up));
  end

  assign count = cnt_q;

  AST_HOLD_WITHOUT_PRESS: assert property (@(posedge clk) disable iff (!rst_n)
    !press |=> $stable(count)); // R8
  AST_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (press && dir_up && count == TOP) |=> (count == '0)); // R4
  AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (press && !dir_up && count == '0) |=> (count == TOP)); // R4
  AST_UP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (press && dir_up && count != TOP) |=> (count > $past(count))); // R2
  AST_DOWN_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (press && !dir_up && count != '0) |=> (count < $past(count))); // R3
endmodule

// File: rtl/btn_step_counter.sv
module btn_step_counter #(
  parameter int CNT_W    = 4,
  parameter int HIST_LEN = 5,
  parameter int TICK_DIV = 250000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             btn_raw,
  input  logic             dir_up,
  output logic [CNT_W-1:0] count
);
  logic btn_s;
  logic tick;
  logic press;

  bsc_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (btn_raw),
    .sync_out (btn_s)
  );

  bsc_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  bsc_hist #(.HIST_LEN(HIST_LEN)) u_hist (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .btn_s (btn_s),
    .press (press)
  );

  bsc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .press  (press),
    .dir_up (dir_up),
    .count  (count)
  );

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |=> (count == '0) || rst_n); // R1
endmodule

// File: tb/btn_step_counter_bench.sv
`timescale 1ns/100ps
module btn_step_counter_bench;
  localparam int CNT_W    = 4;
  localparam int HIST_LEN = 5;
  localparam int TICK_DIV = 4;
  localparam int SAMPLE   = TICK_DIV;
  localparam int SETTLE   = (HIST_LEN + 4) * TICK_DIV + 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_raw = 1'b0;
  logic dir_up = 1'b1;
  logic [CNT_W-1:0] count;

  int errors = 0;
  int checks = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  btn_step_counter #(.CNT_W(CNT_W), .HIST_LEN(HIST_LEN), .TICK_DIV(TICK_DIV)) u_btn_step_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .btn_raw (btn_raw),
    .dir_up  (dir_up),
    .count   (count)
  );

  function automatic int model_next(input int c, input bit up);
    int m = 1 << CNT_W;
    return up ? (c + 1) % m : (c + m - 1) % m;
  endfunction

  task automatic check(input string req, input int exp);
    checks++;
    if (int'(count) != exp) begin
      errors++;
      $display("FAIL %s: count actual=%0d expected=%0d", req, count, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bounce(input int toggles);
    for (int i = 0; i < toggles; i++) begin
      btn_raw = ~btn_raw;
      idle(1 + ($urandom % 2));
    end
  endtask

  // full press: optional bounce in, stable hold, optional bounce out
  task automatic press(input bit up, input int bounces, input int hold);
    @(negedge clk);
    dir_up = up;
    btn_raw = 1'b0;
    bounce(bounces);
    btn_raw = 1'b1;
    idle(hold);
    bounce(bounces);
    btn_raw = 1'b0;
    idle(SETTLE);
    exp_cnt = model_next(exp_cnt, up);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_b7c1));
    idle(3);
    check("R1 during reset", 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 0);

    // R2 directed up steps
    press(1'b1, 0, SETTLE);
    check("R2 single up", exp_cnt);
    press(1'b1, 0, SETTLE);
    check("R2 second up", exp_cnt);

    // R3 directed down
    press(1'b0, 0, SETTLE);
    check("R3 single down", exp_cnt);

    // R5 long hold gives one step
    press(1'b1, 0, 40 * SAMPLE);
    check("R5 long hold one step", exp_cnt);

    // R8 direction toggles while idle
    for (int i = 0; i < 6; i++) begin
      dir_up = ~dir_up;
      idle(3 * SAMPLE);
    end
    check("R8 dir toggle idle", exp_cnt);

    // R6 short glitches
    for (int g = 1; g <= 2 * SAMPLE; g++) begin
      @(negedge clk);
      btn_raw = 1'b1;
      idle(g);
      btn_raw = 1'b0;
      idle(SETTLE);
    end
    check("R6 short pulses ignored", exp_cnt);

    // R4 wrap down from 0
    while (exp_cnt != 0) press(1'b0, 0, SETTLE);
    check("R4 reached zero", 0);
    press(1'b0, 0, SETTLE);
    check("R4 wrap down to 15", 15);
    press(1'b1, 0, SETTLE);
    check("R4 wrap up to 0", 0);

    // R7 bouncy presses
    for (int i = 0; i < 4; i++) begin
      press(1'b1, 3 + i, SETTLE);
      check("R7 bounce single step", exp_cnt);
    end

    // random mix
    for (int i = 0; i < 40; i++) begin
      if (($urandom % 4) == 0) begin
        @(negedge clk);
        btn_raw = 1'b1;
        idle(1 + ($urandom % (2 * SAMPLE)));
        btn_raw = 1'b0;
        idle(SETTLE);
        check("R6 random glitch", exp_cnt);
      end else begin
        press(1'($urandom % 2), $urandom % 5, SETTLE + ($urandom % 60));
        check("R2 R3 R7 random press", exp_cnt);
      end
    end

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    idle(2);
    check("R1 reset mid-run", 0);
    rst_n = 1'b1;
    exp_cnt = 0;
    press(1'b1, 0, SETTLE);
    check("R2 step after reset", exp_cnt);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule